// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block is the digital half of a spread-spectrum clock source. Once per reference clock it produces a signed frequency-offset word for a fractional-N feedback divider. The word is expressed in tenths of a percent of the nominal frequency and carries `FRAC_W` fractional bits. The offset follows a symmetric triangle: it climbs from its minimum to its maximum over the first half of a modulation period and falls back over the second half. A one-cycle marker flags the first cycle of every period.

Three ternary selects configure the profile. Each select arrives already decoded as low, high or middle. The range select sets the period length to 128, 256 or 512 reference cycles. The pair of spread selects picks one of nine codes: four centre-spread depths, four down-spread depths, or no spread. A 2-bit sub-band index trims the depth, so the depth shrinks as the input frequency rises within its range. All selects are captured only at the first cycle of a period, so a period never blends two settings.

Top module: `ssm_profile_gen`

## Requirements
- R1: Each ternary input is 2 bits: 0 = low, 1 = high, 2 = middle, and 3 is treated as middle. With (first spread select, second spread select) written as (hi,lo): (L,L), (L,M), (L,H) and (M,L) are centre codes C0 to C3. (H,H), (H,L), (M,H) and (H,M) are down codes D0 to D3. (M,M) is no spread.
- R2: The period is 128 cycles when the range select is low, 256 when it is high, and 512 when it is middle.
- R3: `period_start` is high for exactly one cycle at the start of each period, and in that cycle the offset equals the profile minimum.
- R4: In a centre code the offset runs from -A to +A and reaches +A in the sample at half the period.
- R5: In a down code the offset runs from -D to 0, never exceeds zero, and reaches 0 at half the period.
- R6: The no-spread code keeps the offset at exactly zero.
- R7: The depth in tenths of a percent, for sub-bands 0/1/2/3, is C0 14/13/12/11, C1 12/11/9/9, C2 6/5/5/4, C3 5/4/4/3, D0 30/27/25/23, D1 22/19/18/17, D2 19/17/15/14 and D3 7/6/6/5. The depth does not depend on the range select.
- R8: Sample j of a period of length P, with h = P/2 and p = j for j <= h, else P-j, equals (-A + 2A*p/h)*2^FRAC_W for a centre code and (-D + D*p/h)*2^FRAC_W for a down code. The result is exact.
- R9: Samples j and P-j of one period are equal for 0 < j < P.
- R10: Changes on any select in the middle of a period have no effect until the next period starts.
- R11: While reset is high the offset is 0 and `period_start` is 0. In the first cycle after reset is released a new period starts with the selects present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| range_sel | input | 2 | Ternary range select (sets period length) |
| spread_hi | input | 2 | First ternary spread select |
| spread_lo | input | 2 | Second ternary spread select |
| sub_band | input | 2 | Sub-band index within the range |
| freq_offset | output | OFS_W (16) | Signed offset, 0.1 % units, FRAC_W fractional bits |
| period_start | output | 1 | One-cycle marker on the first sample of a period |

## Verification
The bench builds the block with its default parameters: `DR_BASE_LOG2` = 7, `FRAC_W` = 8, `OFS_W` = 16 and `AMP_W` = 6. With these values all three period lengths fall within reach, and the counter is driven up to its 511 limit. Because `FRAC_W` is at least the log of the longest half-period, every interpolated sample is an exact integer. The bench therefore compares whole periods sample by sample against its own model for all nine codes in every range, and for every sub-band of the deepest centre and down codes. The mid-period select change and the out-of-range encoding 3 are also covered.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   typedef enum logic [1:0] {
      TRI_LO  = 2'd0,
      TRI_HI  = 2'd1,
      TRI_MID = 2'd2,
      TRI_BAD = 2'd3
   } tri_t;

   typedef enum logic [1:0] {
      SPR_NONE   = 2'd0,
      SPR_CENTER = 2'd1,
      SPR_DOWN   = 2'd2
   } spr_mode_t;

   // range rank: low -> 0, high -> 1, middle (or unused code) -> 2
   function automatic logic [1:0] tri_rank(input tri_t v);
      case (v)
         TRI_LO:  return 2'd0;
         TRI_HI:  return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

   function automatic tri_t tri_clean(input tri_t v);
      return (v == TRI_BAD) ? TRI_MID : v;
   endfunction

endpackage

// File: rtl/ssm_phase_ctr.sv
module ssm_phase_ctr
   import ssm_pkg::*;
#(
   parameter int DR_BASE_LOG2 = 7,
   parameter int CNT_W        = DR_BASE_LOG2 + 2
) (
   input  logic             clk,
   input  logic             rst,
   input  tri_t             range_in,
   input  tri_t             hi_in,
   input  tri_t             lo_in,
   input  logic [1:0]       band_in,
   output logic [CNT_W-1:0] cnt,
   output logic             at_start,
   output logic [1:0]       ridx_eff,
   output tri_t             hi_eff,
   output tri_t             lo_eff,
   output logic [1:0]       band_eff
);

   localparam int NRANGE = 3;

   logic [CNT_W-1:0] last_tab [NRANGE];
   logic [CNT_W-1:0] last_eff;
   logic [1:0]       ridx_q;
   tri_t             hi_q, lo_q;
   logic [1:0]       band_q;

   for (genvar g = 0; g < NRANGE; g++) begin : g_last
      assign last_tab[g] = CNT_W'((1 << (DR_BASE_LOG2 + g)) - 1);
   end

   assign at_start = (cnt == '0);

   // at the period boundary the live pins steer the new period
   always_comb begin
      ridx_eff = at_start ? tri_rank(range_in) : ridx_q;
      hi_eff   = at_start ? tri_clean(hi_in)   : hi_q;
      lo_eff   = at_start ? tri_clean(lo_in)   : lo_q;
      band_eff = at_start ? band_in            : band_q;
      last_eff = last_tab[ridx_eff];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         ridx_q <= 2'd0;
         hi_q   <= TRI_MID;
         lo_q   <= TRI_MID;
         band_q <= 2'd0;
      end else begin
         cnt <= (cnt == last_eff) ? '0 : cnt + 1'b1;
         if (at_start) begin
            ridx_q <= ridx_eff;
            hi_q   <= hi_eff;
            lo_q   <= lo_eff;
            band_q <= band_eff;
         end
      end
   end

   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      (cnt == last_eff) |=> (cnt == '0));

   a_r10_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
      (cnt != '0) |=> ($stable(ridx_q) && $stable(hi_q) && $stable(lo_q) && $stable(band_q)));

endmodule

// File: rtl/ssm_amp_lut.sv
module ssm_amp_lut
   import ssm_pkg::*;
#(
   parameter int AMP_W = 6
) (
   input  tri_t             s_hi,
   input  tri_t             s_lo,
   input  logic [1:0]       band,
   output spr_mode_t        mode,
   output logic [AMP_W-1:0] amp
);

   // rows: C0..C3, D0..D3; columns: sub-band 0..3; units of 0.1 %
   localparam logic [4:0] DEPTH [8][4] = '{
      '{5'd14, 5'd13, 5'd12, 5'd11},
      '{5'd12, 5'd11, 5'd9,  5'd9 },
      '{5'd6,  5'd5,  5'd5,  5'd4 },
      '{5'd5,  5'd4,  5'd4,  5'd3 },
      '{5'd30, 5'd27, 5'd25, 5'd23},
      '{5'd22, 5'd19, 5'd18, 5'd17},
      '{5'd19, 5'd17, 5'd15, 5'd14},
      '{5'd7,  5'd6,  5'd6,  5'd5 }
   };

   logic [2:0] row;

   always_comb begin
      mode = SPR_CENTER;
      row  = 3'd0;
      case ({s_hi, s_lo})
         {TRI_LO,  TRI_LO }: row = 3'd0;
         {TRI_LO,  TRI_MID}: row = 3'd1;
         {TRI_LO,  TRI_HI }: row = 3'd2;
         {TRI_MID, TRI_LO }: row = 3'd3;
         {TRI_HI,  TRI_HI }: begin mode = SPR_DOWN; row = 3'd4; end
         {TRI_HI,  TRI_LO }: begin mode = SPR_DOWN; row = 3'd5; end
         {TRI_MID, TRI_HI }: begin mode = SPR_DOWN; row = 3'd6; end
         {TRI_HI,  TRI_MID}: begin mode = SPR_DOWN; row = 3'd7; end
         default:            mode = SPR_NONE;
      endcase
      amp = (mode == SPR_NONE) ? '0 : AMP_W'(DEPTH[row][band]);
   end

endmodule

// File: rtl/ssm_shaper.sv
module ssm_shaper
   import ssm_pkg::*;
#(
   parameter int DR_BASE_LOG2 = 7,
   parameter int CNT_W        = DR_BASE_LOG2 + 2,
   parameter int FRAC_W       = 8,
   parameter int OFS_W        = 16,
   parameter int AMP_W        = 6
) (
   input  logic [CNT_W-1:0]        cnt,
   input  logic [1:0]              ridx,
   input  spr_mode_t               mode,
   input  logic [AMP_W-1:0]        amp,
   output logic signed [OFS_W-1:0] ofs
);

   localparam int CW1 = CNT_W + 1;
   localparam int PW  = AMP_W + 1 + CW1 + FRAC_W;

   logic [4:0]     hlog;
   logic [CW1-1:0] period, half, pos, cnt_x;
   logic [PW-1:0]  span, prod, scaled, base;

   always_comb begin
      hlog   = 5'(DR_BASE_LOG2 - 1) + 5'(ridx);
      period = CW1'(1) << (hlog + 5'd1);
      half   = CW1'(1) << hlog;
      cnt_x  = {1'b0, cnt};
      pos    = (cnt_x <= half) ? cnt_x : period - cnt_x;
      span   = (mode == SPR_CENTER) ? (PW'(amp) << 1) : PW'(amp);
      prod   = (span * PW'(pos)) << FRAC_W;
      scaled = prod >> hlog;
      base   = PW'(amp) << FRAC_W;
      ofs    = (mode == SPR_NONE) ? '0 : OFS_W'(scaled - base);
   end

endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
   import ssm_pkg::*;
#(
   parameter int DR_BASE_LOG2 = 7,
   parameter int FRAC_W       = 8,
   parameter int OFS_W        = 16,
   parameter int AMP_W        = 6
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [1:0]              range_sel,
   input  logic [1:0]              spread_hi,
   input  logic [1:0]              spread_lo,
   input  logic [1:0]              sub_band,
   output logic signed [OFS_W-1:0] freq_offset,
   output logic                    period_start
);

   localparam int CNT_W = DR_BASE_LOG2 + 2;

   if (FRAC_W < DR_BASE_LOG2 + 1) begin : g_chk_frac
      $error("FRAC_W must cover the longest half-period for exact interpolation");
   end
   if (AMP_W < 5) begin : g_chk_amp
      $error("AMP_W too narrow for the depth table");
   end
   if (OFS_W < AMP_W + FRAC_W + 2) begin : g_chk_ofs
      $error("OFS_W too narrow for the peak offset");
   end

   logic [CNT_W-1:0]        cnt;
   logic                    at_start;
   logic [1:0]              ridx_eff, band_eff;
   tri_t                    hi_eff, lo_eff;
   spr_mode_t               mode_c;
   logic [AMP_W-1:0]        amp_c;
   logic signed [OFS_W-1:0] ofs_c;

   ssm_phase_ctr #(.DR_BASE_LOG2(DR_BASE_LOG2), .CNT_W(CNT_W)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .range_in (tri_t'(range_sel)),
      .hi_in    (tri_t'(spread_hi)),
      .lo_in    (tri_t'(spread_lo)),
      .band_in  (sub_band),
      .cnt      (cnt),
      .at_start (at_start),
      .ridx_eff (ridx_eff),
      .hi_eff   (hi_eff),
      .lo_eff   (lo_eff),
      .band_eff (band_eff)
   );

   ssm_amp_lut #(.AMP_W(AMP_W)) u_lut (
      .s_hi (hi_eff),
      .s_lo (lo_eff),
      .band (band_eff),
      .mode (mode_c),
      .amp  (amp_c)
   );

   ssm_shaper #(
      .DR_BASE_LOG2(DR_BASE_LOG2), .CNT_W(CNT_W), .FRAC_W(FRAC_W),
      .OFS_W(OFS_W), .AMP_W(AMP_W)
   ) u_shape (
      .cnt  (cnt),
      .ridx (ridx_eff),
      .mode (mode_c),
      .amp  (amp_c),
      .ofs  (ofs_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         freq_offset  <= '0;
         period_start <= 1'b0;
      end else begin
         freq_offset  <= ofs_c;
         period_start <= at_start;
      end
   end

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
      period_start |=> !period_start);

   a_r5_down_not_above: assert property (@(posedge clk) disable iff (rst)
      (mode_c == SPR_DOWN) |=> (freq_offset <= 0));

   a_r6_none_is_zero: assert property (@(posedge clk) disable iff (rst)
      (mode_c == SPR_NONE) |=> (freq_offset == 0));

   a_r4_center_bounded: assert property (@(posedge clk) disable iff (rst)
      (mode_c == SPR_CENTER) |=>
         ((int'(freq_offset) <= (int'($past(amp_c)) << FRAC_W)) &&
          (int'(freq_offset) >= -(int'($past(amp_c)) << FRAC_W))));

endmodule

// File: tb/tb_ssm_profile_gen.sv
`timescale 1ns/1ps
module tb_ssm_profile_gen;

   localparam int FW = 8;

   logic              clk = 1'b0;
   logic              rst;
   logic [1:0]        range_sel, spread_hi, spread_lo, sub_band;
   logic signed [15:0] freq_offset;
   logic              period_start;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int smp [0:1023];
   int len;

   always #4 clk = ~clk;

   ssm_profile_gen dut (
      .clk(clk), .rst(rst), .range_sel(range_sel), .spread_hi(spread_hi),
      .spread_lo(spread_lo), .sub_band(sub_band),
      .freq_offset(freq_offset), .period_start(period_start)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---- independent model from the requirements ----
   function automatic int rank(input logic [1:0] v);
      return (v == 2'd0) ? 0 : (v == 2'd1) ? 1 : 2;
   endfunction

   // mode: 0 none, 1 centre, 2 down; row 0..3 within the mode
   function automatic void decode(input logic [1:0] h, input logic [1:0] l,
                                  output int mode, output int row);
      int hh = rank(h), ll = rank(l);
      mode = 1; row = 0;
      if      (hh == 0 && ll == 0) row = 0;
      else if (hh == 0 && ll == 2) row = 1;
      else if (hh == 0 && ll == 1) row = 2;
      else if (hh == 2 && ll == 0) row = 3;
      else if (hh == 1 && ll == 1) begin mode = 2; row = 0; end
      else if (hh == 1 && ll == 0) begin mode = 2; row = 1; end
      else if (hh == 2 && ll == 1) begin mode = 2; row = 2; end
      else if (hh == 1 && ll == 2) begin mode = 2; row = 3; end
      else mode = 0;
   endfunction

   function automatic int depth(input int mode, input int row, input int band);
      int c [4][4] = '{'{14,13,12,11}, '{12,11,9,9}, '{6,5,5,4}, '{5,4,4,3}};
      int d [4][4] = '{'{30,27,25,23}, '{22,19,18,17}, '{19,17,15,14}, '{7,6,6,5}};
      if (mode == 1) return c[row][band];
      if (mode == 2) return d[row][band];
      return 0;
   endfunction

   function automatic int model(input int j, input int per, input int mode, input int a);
      int h = per / 2;
      int p = (j <= h) ? j : per - j;
      if (mode == 1) return -a * (1 << FW) + (2 * a * p * (1 << FW)) / h;
      if (mode == 2) return -a * (1 << FW) + (a * p * (1 << FW)) / h;
      return 0;
   endfunction

   // ---- stimulus helpers ----
   task automatic set_pins(input logic [1:0] r, input logic [1:0] h,
                           input logic [1:0] l, input logic [1:0] b);
      range_sel = r; spread_hi = h; spread_lo = l; sub_band = b;
   endtask

   task automatic wait_start();
      do @(negedge clk); while (!period_start);
   endtask

   // called at the negedge where period_start is seen; records one period
   task automatic capture(input int chg_at, input logic [1:0] r, input logic [1:0] h,
                          input logic [1:0] l, input logic [1:0] b);
      smp[0] = int'(freq_offset);
      len = 1;
      forever begin
         @(negedge clk);
         if (period_start || len >= 1024) break;
         smp[len] = int'(freq_offset);
         len++;
         if (len == chg_at) set_pins(r, h, l, b);
      end
   endtask

   task automatic check_period(input int ridx, input int mode, input int a,
                               input string pk_req, input string tag);
      int per = 128 << ridx;
      int h = per / 2;
      int bad = -1;
      int pk_exp = (mode == 1) ? a * (1 << FW) : 0;
      chk(len == per, "R2", {tag, " period length"}, len, per);
      chk(smp[0] == model(0, per, mode, a), "R3", {tag, " minimum at start"},
          smp[0], model(0, per, mode, a));
      for (int j = 0; j < len && j < per; j++)
         if (bad < 0 && smp[j] != model(j, per, mode, a)) bad = j;
      chk(bad < 0, "R8", {tag, " sample match (first bad index)"}, bad, -1);
      if (len > h) chk(smp[h] == pk_exp, pk_req, {tag, " peak"}, smp[h], pk_exp);
      bad = -1;
      if (len == per)
         for (int j = 1; j < h; j++)
            if (bad < 0 && smp[j] != smp[per - j]) bad = j;
      chk(bad < 0, "R9", {tag, " symmetry (first bad index)"}, bad, -1);
   endtask

   task automatic run_case(input logic [1:0] r, input logic [1:0] h,
                           input logic [1:0] l, input logic [1:0] b,
                           input string pk_req, input string tag);
      int mode, row;
      @(negedge clk);
      set_pins(r, h, l, b);
      wait_start();
      capture(-1, r, h, l, b);
      decode(h, l, mode, row);
      check_period(rank(r), mode, depth(mode, row, int'(b)), pk_req, tag);
   endtask

   // ---- scenarios ----
   task automatic t_reset();
      rst = 1'b1;
      set_pins(2'd0, 2'd2, 2'd2, 2'd0);
      repeat (3) @(negedge clk);
      chk(freq_offset == 0, "R11", "offset in reset", int'(freq_offset), 0);
      chk(period_start == 1'b0, "R11", "marker in reset", int'(period_start), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(period_start == 1'b1, "R11", "period starts after release", int'(period_start), 1);
      chk(freq_offset == 0, "R6", "no-spread offset after release", int'(freq_offset), 0);
   endtask

   task automatic t_all_codes();
      logic [1:0] tv [3] = '{2'd0, 2'd2, 2'd1};
      for (int r = 0; r < 3; r++)
         for (int hi = 0; hi < 3; hi++)
            for (int lo = 0; lo < 3; lo++) begin
               int mode, row;
               string pr;
               decode(tv[hi], tv[lo], mode, row);
               pr = (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R6";
               run_case(2'(r), tv[hi], tv[lo], 2'd0, pr,
                        $sformatf("R1 code hi=%0d lo=%0d range=%0d", tv[hi], tv[lo], r));
            end
   endtask

   task automatic t_sub_bands();
      for (int b = 0; b < 4; b++) begin
         run_case(2'd0, 2'd0, 2'd0, 2'(b), "R7", $sformatf("C0 band %0d", b));
         run_case(2'd1, 2'd1, 2'd1, 2'(b), "R7", $sformatf("D0 band %0d", b));
         run_case(2'd2, 2'd2, 2'd0, 2'(b), "R7", $sformatf("C3 band %0d", b));
      end
   endtask

   task automatic t_mid_change();
      @(negedge clk);
      set_pins(2'd0, 2'd0, 2'd0, 2'd0);
      wait_start();
      capture(10, 2'd2, 2'd1, 2'd1, 2'd3);
      check_period(0, 1, 14, "R10", "R10 old setting kept");
      capture(-1, 2'd2, 2'd1, 2'd1, 2'd3);
      check_period(2, 2, 23, "R10", "R10 new setting next period");
   endtask

   task automatic t_bad_code();
      run_case(2'd3, 2'd3, 2'd3, 2'd0, "R6", "R1 code 3 as middle (none)");
      run_case(2'd3, 2'd0, 2'd3, 2'd1, "R4", "R1 code 3 as middle (C1)");
   endtask

   initial begin
      t_reset();
      t_all_codes();
      t_sub_bands();
      t_mid_change();
      t_bad_code();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule